// File: doc/BRIEF.md
# DMA Bus Grant Controller

This block decides when an external DMA master may take over a processor's system buses. Software first arms it with an enable command. From then on, an asynchronous active-low request from the DMA device is brought into the clock domain. It is held pending until the processor reports the end of its current machine cycle, which suspends the core. The bus is then handed over on the next falling edge of the cycle sync strobe, so a machine cycle is never cut short.

During the grant the acknowledge is low and the bus-release control is high, which puts the address/data and strobe drivers into high impedance. The data-buffer and control-buffer enables are also forced low. The grant lasts as long as the device keeps its request low. Once the request is released, the synchronised release returns the bus on the following clock and the core resumes. A disable command stops new grants from being given, but it never takes away a bus that has already been granted.

Top module: `dma_grant_ctrl`

## Requirements
- R1: While reset is active, and after it ends with no stimulus, the outputs are as follows: dack_no=1, bus_release_o=0, dben_no=1, cben_no=1, core_hold_o=0 and dma_en_o=0.
- R2: A one-clock pulse on en_set_i sets dma_en_o from the next clock. A pulse on en_clr_i clears it. When both are high in the same clock, the flag is cleared.
- R3: While dma_en_o is low, a request is ignored. dack_no stays 1 and core_hold_o stays 0 whatever cyc_end_i and sync_ni do.
- R4: dreq_ni passes through a SYNC_STAGES-flop synchroniser (default 2). A request that falls before clock edge k is first acted on at edge k+SYNC_STAGES.
- R5: core_hold_o rises only in the clock after a cycle in which cyc_end_i was high while a synchronised, enabled request was pending. Before that, it stays 0.
- R6: dack_no falls only in the clock after sync_ni is sampled low, where it was sampled high on the clock before, and only while core_hold_o is already 1.
- R7: While dack_no=0, bus_release_o=1, dben_no=0 and cben_no=0. Otherwise bus_release_o=0, dben_no=1 and cben_no=1. core_hold_o is 1 for the whole grant.
- R8: Once granted, dack_no stays 0 as long as dreq_ni stays low, whatever activity there is on cyc_end_i and sync_ni.
- R9: When dreq_ni returns high, dack_no stays 0 for SYNC_STAGES clocks. It rises, together with the drivers re-enabling and core_hold_o dropping, at the next clock after that (the third clock by default).
- R10: Clearing the enable during a grant does not end the grant. Clearing it while a request is still pending abandons that request: core_hold_o drops within two clocks, and no acknowledge follows.
- R11: If the request is withdrawn before the grant, the pending request is dropped. core_hold_o returns to 0, and a later sync falling edge gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_set_i | input | 1 | One-clock pulse from the DMA-enable I/O command |
| en_clr_i | input | 1 | One-clock pulse from the DMA-disable I/O command |
| dreq_ni | input | 1 | Asynchronous active-low DMA request |
| cyc_end_i | input | 1 | High in the last clock of a machine cycle |
| sync_ni | input | 1 | Active-low cycle sync strobe, synchronous to clk_i |
| dma_en_o | output | 1 | DMA enable flag |
| dack_no | output | 1 | Active-low DMA acknowledge |
| bus_release_o | output | 1 | High puts bus and strobe drivers in high impedance |
| dben_no | output | 1 | Data-buffer enable, forced low during a grant |
| cben_no | output | 1 | Control-buffer enable, forced low during a grant |
| core_hold_o | output | 1 | Suspends the processor core |

## Verification
A corrupted grant state appears at the ports as soon as one clock after the bad transition. It can show as an acknowledge that falls without a preceding sync falling edge. It can show as a hold that rises without an end-of-cycle. It can also show as an acknowledge that fails to track the request or to rise exactly three clocks after release. A wrong enable flag shows directly on dma_en_o, and one clock later as granted or refused requests. The bench sweeps the cycle-end delay, the sync delay and the grant length, and checks every clock of each run against timing worked out from the requirements.

// File: rtl/dgc_pkg.sv
package dgc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_CYC  = 2'd1,
    ST_WAIT_SYNC = 2'd2,
    ST_GRANT     = 2'd3
  } grant_state_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RST_STAGES  = 2;

endpackage

// File: rtl/dgc_rst_sync.sv
module dgc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/dgc_bit_sync.sv
module dgc_bit_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
      // R4: each stage copies its predecessor one clock later
      assert_stage_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> stage_q[g] == $past(stage_q[g-1]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= RESET_VAL;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dgc_fall_det.sv
module dgc_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = strobe_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~strobe_ni;

endmodule

// File: rtl/dgc_enable_reg.sv
module dgc_enable_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);

  logic en_q;
  logic en_d;
  logic en_we;

  always_comb begin
    en_we = set_i | clr_i;
    en_d  = set_i & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

  assert_clear_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !en_q);
  assert_set_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> en_q);
  assert_hold_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(en_q));

endmodule

// File: rtl/dgc_grant_fsm.sv
module dgc_grant_fsm
  import dgc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  input  logic cyc_end_i,
  input  logic sync_fall_i,
  output logic grant_o,
  output logic hold_o
);

  grant_state_e state_q;
  grant_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && en_i) state_d = ST_WAIT_CYC;
      end
      ST_WAIT_CYC: begin
        if (!req_i || !en_i)  state_d = ST_IDLE;
        else if (cyc_end_i)   state_d = ST_WAIT_SYNC;
      end
      ST_WAIT_SYNC: begin
        if (!req_i || !en_i)  state_d = ST_IDLE;
        else if (sync_fall_i) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        if (!req_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign grant_o = (state_q == ST_GRANT);
  assign hold_o  = (state_q == ST_WAIT_SYNC) || (state_q == ST_GRANT);

  // R6: a grant starts only from a pending, suspended request on a sync fall
  assert_grant_on_sync_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> ($past(sync_fall_i) && $past(hold_o)));
  // R3: no grant without the enable
  assert_grant_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(en_i));
  // R5: suspension follows an end-of-cycle indication
  assert_hold_after_cycle_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(cyc_end_i));
  // R8 / R10: a held request keeps the grant even if the enable is gone
  assert_grant_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && req_i) |=> grant_o);
  // R9: release of the synchronised request ends the grant on the next clock
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !req_i) |=> !grant_o);
  // R11: withdrawn pending request drops the hold
  assert_pending_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !grant_o && !req_i) |=> !hold_o);

endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl
  import dgc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned RST_STAGES  = DEF_RST_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic dreq_ni,
  input  logic cyc_end_i,
  input  logic sync_ni,
  output logic dma_en_o,
  output logic dack_no,
  output logic bus_release_o,
  output logic dben_no,
  output logic cben_no,
  output logic core_hold_o
);

  logic rst_n_int;
  logic req_async;
  logic req_sync;
  logic sync_fall;
  logic en_flag;
  logic grant;
  logic hold;

  assign req_async = ~dreq_ni;

  dgc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_int)
  );

  dgc_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (req_async),
    .q_o    (req_sync)
  );

  dgc_fall_det u_sync_fall (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .strobe_ni (sync_ni),
    .fall_o    (sync_fall)
  );

  dgc_enable_reg u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .set_i  (en_set_i),
    .clr_i  (en_clr_i),
    .en_o   (en_flag)
  );

  dgc_grant_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .req_i       (req_sync),
    .en_i        (en_flag),
    .cyc_end_i   (cyc_end_i),
    .sync_fall_i (sync_fall),
    .grant_o     (grant),
    .hold_o      (hold)
  );

  assign dma_en_o      = en_flag;
  assign dack_no       = ~grant;
  assign bus_release_o = grant;
  assign dben_no       = ~grant;
  assign cben_no       = ~grant;
  assign core_hold_o   = hold;

  // R7: the core stays suspended for the whole time the bus is released
  assert_hold_covers_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !dack_no |-> core_hold_o);
  // R3: an unarmed controller never suspends the core from idle
  assert_idle_when_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!core_hold_o && !dma_en_o) |=> !core_hold_o);

endmodule

// File: tb/dma_grant_ctrl_test.sv
module dma_grant_ctrl_test;

  logic clk = 1'b0;
  logic rst_ni;
  logic en_set_i, en_clr_i, dreq_ni, cyc_end_i, sync_ni;
  logic dma_en_o, dack_no, bus_release_o, dben_no, cben_no, core_hold_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dma_grant_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .dreq_ni(dreq_ni), .cyc_end_i(cyc_end_i), .sync_ni(sync_ni),
    .dma_en_o(dma_en_o), .dack_no(dack_no), .bus_release_o(bus_release_o),
    .dben_no(dben_no), .cben_no(cben_no), .core_hold_o(core_hold_o)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_bus(input string req, input logic granted);
    chk(req, dack_no, ~granted, "dack_no");
    chk(req, bus_release_o, granted, "bus_release_o");
    chk(req, dben_no, ~granted, "dben_no");
    chk(req, cben_no, ~granted, "cben_no");
  endtask

  task automatic pulse_set();
    en_set_i = 1'b1; tick(); en_set_i = 1'b0;
  endtask

  task automatic pulse_clr();
    en_clr_i = 1'b1; tick(); en_clr_i = 1'b0;
  endtask

  // Request, wait for synchroniser plus idle exit, then end a machine cycle
  task automatic reach_pending(input int pre_cyc);
    dreq_ni = 1'b0;
    for (int i = 0; i < 3 + pre_cyc; i++) begin
      tick();
      chk("R5", core_hold_o, 1'b0, "hold before cycle end");
      chk("R4", dack_no, 1'b1, "dack while synchronising");
    end
    cyc_end_i = 1'b1; tick(); cyc_end_i = 1'b0;
    chk("R5", core_hold_o, 1'b1, "hold after cycle end");
    chk("R6", dack_no, 1'b1, "dack before sync fall");
  endtask

  task automatic release_and_check();
    dreq_ni = 1'b1;
    tick(); chk("R9", dack_no, 1'b0, "dack 1 clock after release");
    tick(); chk("R9", dack_no, 1'b0, "dack 2 clocks after release");
    tick(); chk_bus("R9", 1'b0);
    chk("R9", core_hold_o, 1'b0, "hold after release");
    tick();
  endtask

  task automatic run_grant(input int pre_cyc, input int sync_wait, input int hold_len);
    reach_pending(pre_cyc);
    for (int i = 0; i < sync_wait; i++) begin
      tick();
      chk("R6", dack_no, 1'b1, "dack waiting for sync");
      chk("R5", core_hold_o, 1'b1, "hold waiting for sync");
    end
    sync_ni = 1'b0; tick(); sync_ni = 1'b1;
    chk_bus("R6", 1'b1);
    chk("R7", core_hold_o, 1'b1, "hold during grant");
    for (int i = 0; i < hold_len; i++) begin
      sync_ni   = i[0];
      cyc_end_i = ~i[0];
      tick();
      chk_bus("R8", 1'b1);
    end
    sync_ni = 1'b1; cyc_end_i = 1'b0;
    release_and_check();
  endtask

  initial begin
    rst_ni = 1'b0; en_set_i = 1'b0; en_clr_i = 1'b0;
    dreq_ni = 1'b1; cyc_end_i = 1'b0; sync_ni = 1'b1;
    repeat (3) tick();
    chk_bus("R1", 1'b0);
    chk("R1", core_hold_o, 1'b0, "hold in reset");
    chk("R1", dma_en_o, 1'b0, "enable in reset");
    rst_ni = 1'b1;
    repeat (4) tick();
    chk_bus("R1", 1'b0);
    chk("R1", dma_en_o, 1'b0, "enable after reset");

    // R3: disabled controller ignores everything
    dreq_ni = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cyc_end_i = i[0]; sync_ni = i[1];
      tick();
      chk("R3", dack_no, 1'b1, "dack while disabled");
      chk("R3", core_hold_o, 1'b0, "hold while disabled");
    end
    dreq_ni = 1'b1; cyc_end_i = 1'b0; sync_ni = 1'b1;
    repeat (4) tick();

    // R2: enable flag set/clear and clear priority
    pulse_set(); chk("R2", dma_en_o, 1'b1, "after set");
    pulse_clr(); chk("R2", dma_en_o, 1'b0, "after clear");
    en_set_i = 1'b1; en_clr_i = 1'b1; tick(); en_set_i = 1'b0; en_clr_i = 1'b0;
    chk("R2", dma_en_o, 1'b0, "set and clear together");
    pulse_set(); chk("R2", dma_en_o, 1'b1, "set again");

    // Sweep: cycle-end delay, sync delay, grant length
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 4; s++)
        for (int h = 1; h < 4; h++)
          run_grant(p, s, h);

    // R10: disable during a grant does not abort it
    reach_pending(0);
    sync_ni = 1'b0; tick(); sync_ni = 1'b1;
    chk_bus("R10", 1'b1);
    pulse_clr();
    chk("R10", dma_en_o, 1'b0, "flag cleared during grant");
    for (int i = 0; i < 4; i++) begin
      tick(); chk_bus("R10", 1'b1);
    end
    release_and_check();
    pulse_set();

    // R10: disable while pending abandons the request
    reach_pending(1);
    pulse_clr();
    chk("R10", core_hold_o, 1'b1, "hold one clock after disable");
    tick(); chk("R10", core_hold_o, 1'b0, "hold two clocks after disable");
    sync_ni = 1'b0; tick(); sync_ni = 1'b1;
    chk("R10", dack_no, 1'b1, "no grant after disable");
    tick(); chk("R10", dack_no, 1'b1, "still no grant");
    dreq_ni = 1'b1; repeat (4) tick();
    pulse_set();

    // R11: request withdrawn before grant
    reach_pending(2);
    dreq_ni = 1'b1;
    repeat (3) tick();
    chk("R11", core_hold_o, 1'b0, "hold after withdrawal");
    sync_ni = 1'b0; tick(); sync_ni = 1'b1;
    chk("R11", dack_no, 1'b1, "no grant after withdrawal");
    tick(); chk_bus("R11", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule